// File: doc/BRIEF.md
# Logarithmic PCM Successive-Approximation Encoder Sequencer

This block is the digital control for a sign/chord/step companding encoder. The analog side is external: a trial DAC built from a capacitor array and a comparator. Once per 8 kHz sampling period a start pulse launches a binary search over eight comparator decisions. The first decision resolves the polarity. The next three decide the 3-bit chord, most significant bit first. The last four decide the 4-bit step inside that chord.

On every search cycle the block presents a trial code to the DAC and samples the comparator. A trial bit is set tentatively. It is kept only when the comparator reports that the input lies at or above the trial level; otherwise it is cleared before the next bit is tried. The finished word leaves on `code_o`, rewritten in one of three line formats chosen by `fmt_i`. The polarity bit is also copied to `sign_o`, where an offset-cancelling loop can integrate it.

Top module: `pcm_sar_encoder`

## Requirements
- R1: The codeword has the polarity in bit 7, the chord in bits 6..4 and the step in bits 3..0. The polarity bit is 1 when the comparator reports true in the first search cycle. The 7-bit magnitude equals the largest trial magnitude that the comparator accepts.
- R2: In the first search cycle after a start is accepted, `trial_o` is 8'h80. Each later trial keeps the bits already resolved, holds the bit just decided at the comparator's answer, and sets the next lower bit.
- R3: `done_o` is high for exactly one cycle, starting at the eighth rising edge after the edge that samples `start_i`.
- R4: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`. That is eight cycles.
- R5: With `fmt_i` = 0 the output is the plain sign-magnitude word.
- R6: With `fmt_i` = 1 the output keeps bit 7 and inverts bits 6..0.
- R7: With `fmt_i` = 2 the output is the sign-magnitude word with bits 0, 2, 4 and 6 inverted (XOR 8'h55).
- R8: With `fmt_i` = 3 the output is the plain sign-magnitude word. `fmt_i` is sampled at the edge that completes the conversion.
- R9: `sign_o` equals bit 7 of the finished codeword and changes only when `done_o` rises.
- R10: `code_o` and `sign_o` hold their values between `done_o` pulses, whatever the comparator, format and start inputs do.
- R11: A start request that arrives while `busy_o` is high is ignored. It neither restarts nor delays the conversion in progress.
- R12: Asynchronous active-low reset clears `trial_o`, `code_o`, `sign_o`, `busy_o` and `done_o`. The sequencer returns to idle even in the middle of a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a conversion |
| cmp_ge_i | input | 1 | Comparator: input at or above the current trial level |
| fmt_i | input | 2 | Output format select |
| trial_o | output | 8 | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle strobe: new codeword valid |
| code_o | output | 8 | Formatted codeword |
| sign_o | output | 1 | Polarity of the latest codeword |

## Verification
A trial code is due one edge after the previous decision. It is read at the falling edge that follows, and the bench comparator model answers from it combinationally. The codeword, `sign_o` and `done_o` are all due at the eighth rising edge after the start edge. The bench counts those edges, checks at the falling edge after the eighth, and requires `done_o` to be low at every falling edge before that and one after. Hold and ignored-start checks sample the outputs again several cycles after the disturbing stimulus.

// File: rtl/pcm_sar_encoder.sv
module pcm_sar_encoder #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmp_ge_i,
  input  logic [1:0]    fmt_i,
  output logic [CW-1:0] trial_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] code_o,
  output logic          sign_o
);
  localparam int IW = $clog2(CW);
  localparam logic [CW-1:0] SEED = CW'(1) << (CW - 1);
  localparam logic [CW-1:0] ALT  = {(CW/2){2'b01}};

  logic [CW-1:0] trial_q, resolved, fmt_word;
  logic [IW-1:0] idx_q;
  logic          busy_q;

  always_comb begin
    resolved = trial_q;
    resolved[idx_q] = cmp_ge_i;
  end

  always_comb begin
    case (fmt_i)
      2'd1:    fmt_word = {resolved[CW-1], ~resolved[CW-2:0]};
      2'd2:    fmt_word = resolved ^ ALT;
      default: fmt_word = resolved;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      done_o  <= 1'b0;
      code_o  <= '0;
      sign_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_q) begin
        if (idx_q == '0) begin
          busy_q  <= 1'b0;
          done_o  <= 1'b1;
          trial_q <= resolved;
          code_o  <= fmt_word;
          sign_o  <= resolved[CW-1];
        end else begin
          trial_q <= resolved | (CW'(1) << (idx_q - IW'(1)));
          idx_q   <= idx_q - IW'(1);
        end
      end else if (start_i) begin
        trial_q <= SEED;
        idx_q   <= IW'(CW - 1);
        busy_q  <= 1'b1;
      end
    end
  end

  assign trial_o = trial_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/pcm_sar_encoder_chk.sv
module pcm_sar_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] trial_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] code_o,
  input logic       sign_o
);
  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy_o ? run_q + 4'd1 : 4'd0;
  end

  a_r2_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> trial_o == 8'h80);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r4_busy_eight: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> run_q == 4'd8);

  a_r11_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> run_q < 4'd8);

  a_r9_sign_match: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> sign_o == code_o[7]);

  a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(code_o) && $stable(sign_o)));
endmodule

bind pcm_sar_encoder pcm_sar_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trial_o(trial_o), .busy_o(busy_o),
  .done_o(done_o), .code_o(code_o), .sign_o(sign_o)
);

// File: tb/pcm_sar_encoder_tb.sv
module pcm_sar_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] fmt_i = 2'd0;
  logic       in_pos = 1'b1;
  logic [6:0] in_mag = 7'd0;
  logic       cmp_ge_i;
  logic [7:0] trial_o, code_o;
  logic       busy_o, done_o, sign_o;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  // ideal comparator: a zero trial magnitude only occurs in the polarity cycle
  assign cmp_ge_i = (trial_o[6:0] == 7'd0) ? in_pos : (in_mag >= trial_o[6:0]);

  pcm_sar_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_ge_i(cmp_ge_i),
    .fmt_i(fmt_i), .trial_o(trial_o), .busy_o(busy_o), .done_o(done_o),
    .code_o(code_o), .sign_o(sign_o)
  );

  // {pos, mag, fmt, expected code}
  localparam logic [17:0] VEC [12] = '{
    {1'b1, 7'h00, 2'd0, 8'h80}, {1'b1, 7'h7F, 2'd0, 8'hFF},
    {1'b0, 7'h7F, 2'd0, 8'h7F}, {1'b0, 7'h00, 2'd0, 8'h00},
    {1'b1, 7'h35, 2'd0, 8'hB5}, {1'b1, 7'h35, 2'd1, 8'hCA},
    {1'b0, 7'h12, 2'd1, 8'h6D}, {1'b1, 7'h35, 2'd2, 8'hE0},
    {1'b0, 7'h00, 2'd2, 8'h55}, {1'b1, 7'h7F, 2'd2, 8'hAA},
    {1'b0, 7'h4B, 2'd3, 8'h4B}, {1'b1, 7'h01, 2'd1, 8'hFE}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // start sampled at edge E0; hold_start keeps start high through E8
  task automatic convert(input logic [7:0] exp, input string req, input bit hold_start);
    bit early = 0;
    @(negedge clk) start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!hold_start) start_i = 1'b0;
    chk("R4 busy after start", busy_o, 1);
    for (int i = 1; i < 8; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (done_o) early = 1;
    end
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk("R3 done not early", early, 0);
    chk("R3 done at eighth edge", done_o, 1);
    chk("R4 busy low at done", busy_o, 0);
    chk(req, code_o, exp);
    chk("R9 sign output", sign_o, exp[7]);
    @(negedge clk);
    chk("R3 done one cycle", done_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    #5;
    chk("R12 reset trial", trial_o, 0);
    chk("R12 reset code", code_o, 0);
    chk("R12 reset flags", {busy_o, done_o, sign_o}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      in_pos = VEC[i][17];
      in_mag = VEC[i][16:10];
      fmt_i  = VEC[i][9:8];
      case (VEC[i][9:8])
        2'd0: convert(VEC[i][7:0], "R1 R5 plain", 0);
        2'd1: convert(VEC[i][7:0], "R6 inverted magnitude", 0);
        2'd2: convert(VEC[i][7:0], "R7 even-bit inversion", 0);
        default: convert(VEC[i][7:0], "R8 mode 3 plain", 0);
      endcase
    end

    // R2: trial progression for +0x35
    in_pos = 1'b1; in_mag = 7'h35; fmt_i = 2'd0;
    @(negedge clk) start_i = 1'b1;
    @(posedge clk); @(negedge clk) start_i = 1'b0;
    chk("R2 first trial", trial_o, 8'h80);
    @(posedge clk); @(negedge clk);
    chk("R2 second trial", trial_o, 8'hC0);
    @(posedge clk); @(negedge clk);
    chk("R2 third trial", trial_o, 8'hA0);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R1 result after progression", code_o, 8'hB5);

    // R10: outputs held while inputs change
    in_pos = 1'b0; in_mag = 7'h11; fmt_i = 2'd1;
    repeat (5) @(negedge clk);
    chk("R10 code held", code_o, 8'hB5);
    chk("R10 sign held", sign_o, 1);

    // R11: start held high for the whole conversion
    in_pos = 1'b0; in_mag = 7'h2C; fmt_i = 2'd0;
    convert(8'h2C, "R11 start ignored while busy", 1);

    // R12: reset in mid-conversion
    @(negedge clk) start_i = 1'b1;
    @(posedge clk); @(negedge clk) start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R12 mid reset busy", busy_o, 0);
    chk("R12 mid reset trial", trial_o, 0);
    chk("R12 mid reset code", code_o, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R12 idle after reset", {busy_o, done_o}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule